// File: doc/BRIEF.md
# Bit-Plane AND-Popcount Dot-Product Engine

This block computes the dot product of two unsigned integer vectors without a multiplier. After a start request it takes the vector elements one pair per cycle and stores them transposed, so that each bit position of the inputs and each bit position of the weights forms one row of bits across all lanes. It then visits every pair of an input row and a weight row, one pair per cycle. For each pair it ANDs the two rows, counts the ones, shifts the count left by the sum of the two bit positions and adds it into an accumulator.

Vector length, input precision and weight precision are set at start. With one bit on both sides the whole job reduces to a single AND and count. When the last pair has been added, a one-cycle done pulse marks the final sum. That sum stays on the result port until the next start.

Top module: `bitplane_mac`

## Requirements
- R1: While reset is held and after it is released, `done` and `in_ready` are low and `result` is zero.
- R2: A `start` seen in the idle phase takes a new job. It latches the length and both precisions, clears `result` to zero and raises `in_ready` in the next cycle. A length or precision of 0 is taken as 1. A value above its maximum (LANES, XBITS, WBITS) is taken as that maximum.
- R3: While `in_ready` is high, each cycle with `in_valid` high stores one element pair into the next lane, starting at lane 0. `in_ready` falls after exactly the configured number of pairs. `in_valid` has no effect while `in_ready` is low.
- R4: `result` at the done pulse equals the sum over the loaded lanes of x*w. Input bits at or above the input precision and weight bits at or above the weight precision are ignored.
- R5: With input and weight precision both 1, `result` is the number of lanes whose x bit 0 and w bit 0 are both 1.
- R6: Exactly I*W cycles, one per plane pair, pass between the cycle in which the last element is accepted and the cycle in which `done` is high. The weight bit is the outer loop and the input bit the inner loop.
- R7: `done` is high for exactly one cycle per job. `result` keeps its value from that cycle until the next accepted `start`.
- R8: `start` has no effect while a job is loading, running or finishing.
- R9: At full length with both precisions at maximum and every element at full scale, the result is exact with no overflow.
- R10: Lanes at or above the configured length contribute nothing, even when a previous longer job filled them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a job (accepted only when idle) |
| len | input | $clog2(LANES+1) | Number of element pairs in the job |
| xprec | input | $clog2(XBITS+1) | Input precision in bits |
| wprec | input | $clog2(WBITS+1) | Weight precision in bits |
| in_valid | input | 1 | Element pair present on in_x / in_w |
| in_x | input | XBITS | Input element, unsigned |
| in_w | input | WBITS | Weight element, unsigned |
| in_ready | output | 1 | High while element pairs are being accepted |
| done | output | 1 | One-cycle pulse when the sum is final |
| result | output | XBITS+WBITS+$clog2(LANES+1) | Accumulated dot product |

## Verification
Stale lane contents are hard to expose from the ports. The stimulus runs a full-length job with large values, then a short job, so that lanes left unwritten would change the sum if they were not cleared. A second hard case is stray control during computation: the bench holds `in_valid` high with junk data and pulses `start` with a different configuration while pairs are still being visited. The expected sum and the cycle count must both stay unchanged. Every combination of input and weight precision is run with random elements whose bits above the precision are set, and the busy window is measured against I*W.

// File: rtl/bpm_pkg.sv
package bpm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_RUN  = 2'd2,
        PH_FIN  = 2'd3
    } phase_t;

    localparam int DEF_LANES = 16;
    localparam int DEF_XBITS = 8;
    localparam int DEF_WBITS = 8;

    function automatic int acc_width(input int lanes, input int xb, input int wb);
        return xb + wb + $clog2(lanes + 1);
    endfunction

    function automatic int sel_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/bpm_plane_store.sv
module bpm_plane_store #(
    parameter int LANES = 16,
    parameter int BITS  = 8,
    localparam int IDX_W  = bpm_pkg::sel_width(LANES),
    localparam int PREC_W = $clog2(BITS + 1),
    localparam int SEL_W  = bpm_pkg::sel_width(BITS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PREC_W-1:0] prec,
    input  logic [BITS-1:0]   wr_val,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [LANES-1:0]  rd_plane
);
    logic [LANES-1:0] plane [BITS];
    logic [BITS-1:0]  keep;

    always_comb begin
        for (int i = 0; i < BITS; i++) begin
            keep[i] = (PREC_W'(i) < prec);
        end
    end

    for (genvar b = 0; b < BITS; b++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                plane[b] <= '0;
            end else if (wr_en) begin
                plane[b][wr_idx] <= wr_val[b] & keep[b];
            end
        end
    end

    assign rd_plane = plane[rd_sel];

endmodule

// File: rtl/bpm_pair_seq.sv
module bpm_pair_seq #(
    parameter int XBITS = 8,
    parameter int WBITS = 8,
    localparam int PX_W = $clog2(XBITS + 1),
    localparam int PW_W = $clog2(WBITS + 1),
    localparam int SX_W = bpm_pkg::sel_width(XBITS),
    localparam int SW_W = bpm_pkg::sel_width(WBITS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            step,
    input  logic [PX_W-1:0] xprec,
    input  logic [PW_W-1:0] wprec,
    output logic [SX_W-1:0] xsel,
    output logic [SW_W-1:0] wsel,
    output logic            last
);
    logic x_top;
    logic w_top;

    assign x_top = (PX_W'(xsel) == xprec - PX_W'(1));
    assign w_top = (PW_W'(wsel) == wprec - PW_W'(1));
    assign last  = x_top && w_top;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            xsel <= '0;
            wsel <= '0;
        end else if (step) begin
            if (x_top) begin
                xsel <= '0;
                wsel <= w_top ? '0 : wsel + SW_W'(1);
            end else begin
                xsel <= xsel + SX_W'(1);
            end
        end
    end

    // R6
    xsel_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        step |-> (PX_W'(xsel) < xprec));

    // R6
    weight_outer_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !x_top) |=> $stable(wsel));

endmodule

// File: rtl/bpm_accum.sv
module bpm_accum #(
    parameter int LANES = 16,
    parameter int XBITS = 8,
    parameter int WBITS = 8,
    localparam int ACC_W = bpm_pkg::acc_width(LANES, XBITS, WBITS),
    localparam int CNT_W = $clog2(LANES + 1),
    localparam int SX_W  = bpm_pkg::sel_width(XBITS),
    localparam int SW_W  = bpm_pkg::sel_width(WBITS),
    localparam int SH_W  = $clog2(XBITS + WBITS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic [LANES-1:0] xplane,
    input  logic [LANES-1:0] wplane,
    input  logic [SX_W-1:0]  xsel,
    input  logic [SW_W-1:0]  wsel,
    output logic [ACC_W-1:0] acc
);
    logic [LANES-1:0] both;
    logic [CNT_W-1:0] ones;
    logic [SH_W-1:0]  sh;
    logic [ACC_W-1:0] term;

    assign both = xplane & wplane;

    always_comb begin
        ones = '0;
        for (int i = 0; i < LANES; i++) begin
            ones = ones + CNT_W'(both[i]);
        end
    end

    assign sh   = SH_W'(xsel) + SH_W'(wsel);
    assign term = ACC_W'(ones) << sh;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
        end else if (en) begin
            acc <= acc + term;
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        en |=> (acc >= $past(acc)));

endmodule

// File: rtl/bitplane_mac.sv
module bitplane_mac #(
    parameter int LANES = bpm_pkg::DEF_LANES,
    parameter int XBITS = bpm_pkg::DEF_XBITS,
    parameter int WBITS = bpm_pkg::DEF_WBITS,
    localparam int LEN_W = $clog2(LANES + 1),
    localparam int IDX_W = bpm_pkg::sel_width(LANES),
    localparam int PX_W  = $clog2(XBITS + 1),
    localparam int PW_W  = $clog2(WBITS + 1),
    localparam int SX_W  = bpm_pkg::sel_width(XBITS),
    localparam int SW_W  = bpm_pkg::sel_width(WBITS),
    localparam int ACC_W = bpm_pkg::acc_width(LANES, XBITS, WBITS),
    localparam int RC_W  = $clog2(XBITS * WBITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [LEN_W-1:0] len,
    input  logic [PX_W-1:0]  xprec,
    input  logic [PW_W-1:0]  wprec,
    input  logic             in_valid,
    input  logic [XBITS-1:0] in_x,
    input  logic [WBITS-1:0] in_w,
    output logic             in_ready,
    output logic             done,
    output logic [ACC_W-1:0] result
);
    import bpm_pkg::*;

    phase_t           phase;
    logic [LEN_W-1:0] len_q;
    logic [PX_W-1:0]  xprec_q;
    logic [PW_W-1:0]  wprec_q;
    logic [LEN_W-1:0] idx;

    logic [LEN_W-1:0] len_fix;
    logic [PX_W-1:0]  xprec_fix;
    logic [PW_W-1:0]  wprec_fix;

    logic accept;
    logic take;
    logic running;
    logic last;

    logic [LANES-1:0] xplane;
    logic [LANES-1:0] wplane;
    logic [SX_W-1:0]  xsel;
    logic [SW_W-1:0]  wsel;

    always_comb begin
        if (len == '0)                      len_fix = LEN_W'(1);
        else if (len > LEN_W'(LANES))       len_fix = LEN_W'(LANES);
        else                                len_fix = len;
        if (xprec == '0)                    xprec_fix = PX_W'(1);
        else if (xprec > PX_W'(XBITS))      xprec_fix = PX_W'(XBITS);
        else                                xprec_fix = xprec;
        if (wprec == '0)                    wprec_fix = PW_W'(1);
        else if (wprec > PW_W'(WBITS))      wprec_fix = PW_W'(WBITS);
        else                                wprec_fix = wprec;
    end

    assign accept   = (phase == PH_IDLE) && start;
    assign take     = (phase == PH_LOAD) && in_valid;
    assign running  = (phase == PH_RUN);
    assign in_ready = (phase == PH_LOAD);
    assign done     = (phase == PH_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            len_q   <= LEN_W'(1);
            xprec_q <= PX_W'(1);
            wprec_q <= PW_W'(1);
            idx     <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase   <= PH_LOAD;
                        len_q   <= len_fix;
                        xprec_q <= xprec_fix;
                        wprec_q <= wprec_fix;
                        idx     <= '0;
                    end
                end
                PH_LOAD: begin
                    if (in_valid) begin
                        idx <= idx + LEN_W'(1);
                        if (idx == len_q - LEN_W'(1)) phase <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (last) phase <= PH_FIN;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    bpm_plane_store #(.LANES(LANES), .BITS(XBITS)) u_xstore (
        .clk(clk), .rst(rst), .clr(accept), .wr_en(take),
        .wr_idx(idx[IDX_W-1:0]), .prec(xprec_q), .wr_val(in_x),
        .rd_sel(xsel), .rd_plane(xplane)
    );

    bpm_plane_store #(.LANES(LANES), .BITS(WBITS)) u_wstore (
        .clk(clk), .rst(rst), .clr(accept), .wr_en(take),
        .wr_idx(idx[IDX_W-1:0]), .prec(wprec_q), .wr_val(in_w),
        .rd_sel(wsel), .rd_plane(wplane)
    );

    bpm_pair_seq #(.XBITS(XBITS), .WBITS(WBITS)) u_seq (
        .clk(clk), .rst(rst), .clr(accept), .step(running),
        .xprec(xprec_q), .wprec(wprec_q),
        .xsel(xsel), .wsel(wsel), .last(last)
    );

    bpm_accum #(.LANES(LANES), .XBITS(XBITS), .WBITS(WBITS)) u_acc (
        .clk(clk), .rst(rst), .clr(accept), .en(running),
        .xplane(xplane), .wplane(wplane), .xsel(xsel), .wsel(wsel),
        .acc(result)
    );

    logic [RC_W-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || accept) run_cnt <= '0;
        else if (running)  run_cnt <= run_cnt + RC_W'(1);
    end

    // R6
    pair_count_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (run_cnt == RC_W'(xprec_q) * RC_W'(wprec_q)));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IDLE && !start) |=> $stable(result));

    // R3
    load_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_valid) |-> (idx < len_q));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        running |=> (phase == PH_RUN || phase == PH_FIN));

endmodule

// File: tb/bitplane_mac_test.sv
`timescale 1ns/1ps
module bitplane_mac_test;
    localparam int LANES = 16;
    localparam int XB = 8;
    localparam int WB = 8;
    localparam int ACC_W = XB + WB + $clog2(LANES + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [4:0] len = '0;
    logic [3:0] xprec = '0;
    logic [3:0] wprec = '0;
    logic in_valid = 1'b0;
    logic [XB-1:0] in_x = '0;
    logic [WB-1:0] in_w = '0;
    logic in_ready;
    logic done;
    logic [ACC_W-1:0] result;

    always #10 clk = ~clk;

    bitplane_mac uut (
        .clk(clk), .rst(rst), .start(start), .len(len), .xprec(xprec),
        .wprec(wprec), .in_valid(in_valid), .in_x(in_x), .in_w(in_w),
        .in_ready(in_ready), .done(done), .result(result)
    );

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 0;

    int xs [LANES];
    int ws [LANES];

    longint q_res [$];
    int     q_cyc [$];
    string  q_tag [$];

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Scoreboard monitor: measures the busy window and compares results at done.
    int  cnt = 0;
    bit  holding = 0;
    bit  prev_done = 0;
    longint held = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (prev_done) check(done == 1'b0, "R7 done width", done, 0);
            if (in_ready) begin
                cnt = 0;
                holding = 0;
            end else if (done) begin
                if (q_res.size() == 0) begin
                    check(0, "R7 unexpected done", 1, 0);
                end else begin
                    longint er;
                    int ec;
                    string tg;
                    er = q_res.pop_front();
                    ec = q_cyc.pop_front();
                    tg = q_tag.pop_front();
                    check(result == ACC_W'(er), tg, result, er);
                    check(cnt == ec, "R6 cycles", cnt, ec);
                end
                holding = 1;
                held = result;
            end else begin
                if (holding) check(result == ACC_W'(held), "R7 hold", result, held);
                else cnt++;
            end
            prev_done = done;
        end
    end

    task automatic run_job(input int n, input int xp, input int wp,
                           input string tag, input bit junk, input bit poke);
        int en, exq, ewq, k;
        longint sum;
        en  = (n == 0) ? 1 : (n > LANES ? LANES : n);
        exq = (xp == 0) ? 1 : (xp > XB ? XB : xp);
        ewq = (wp == 0) ? 1 : (wp > WB ? WB : wp);
        sum = 0;
        for (int i = 0; i < en; i++)
            sum += longint'(xs[i] & ((1 << exq) - 1)) * longint'(ws[i] & ((1 << ewq) - 1));
        q_res.push_back(sum);
        q_cyc.push_back(exq * ewq);
        q_tag.push_back(tag);

        @(negedge clk);
        start = 1'b1;
        len = 5'(n);
        xprec = 4'(xp);
        wprec = 4'(wp);
        @(negedge clk);
        start = 1'b0;
        // R2: job taken, result cleared, loading open
        check(in_ready == 1'b1, "R2 ready", in_ready, 1);
        check(result == '0, "R2 clear", result, 0);
        for (int i = 0; i < en; i++) begin
            in_valid = 1'b1;
            in_x = XB'(xs[i]);
            in_w = WB'(ws[i]);
            @(negedge clk);
        end
        // R3: ready falls after exactly en pairs
        check(in_ready == 1'b0, "R3 ready low", in_ready, 0);
        if (junk) begin
            in_x = 8'hFF;
            in_w = 8'hFF;
        end else begin
            in_valid = 1'b0;
        end
        if (poke) begin
            start = 1'b1;
            len = 5'd2;
            xprec = 4'd1;
            wprec = 4'd1;
        end
        k = 0;
        while (!done && k < 200) begin
            @(negedge clk);
            start = 1'b0;
            k++;
        end
        start = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(done == 1'b0, "R1 done", done, 0);
        check(in_ready == 1'b0, "R1 ready", in_ready, 0);
        check(result == '0, "R1 result", result, 0);
        rst = 1'b0;
        // R3: in_valid while idle is ignored
        in_valid = 1'b1;
        in_x = 8'hFF;
        in_w = 8'hFF;
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0 && result == '0, "R1 idle", result, 0);

        // R9: full scale
        for (int i = 0; i < LANES; i++) begin xs[i] = 255; ws[i] = 255; end
        run_job(16, 8, 8, "R9 full scale", 0, 0);

        // R10: shorter job after full one
        for (int i = 0; i < LANES; i++) begin xs[i] = 0; ws[i] = 0; end
        xs[0] = 3; ws[0] = 5; xs[1] = 7; ws[1] = 2; xs[2] = 1; ws[2] = 9;
        run_job(3, 4, 4, "R10 stale lanes", 0, 0);

        // R5: binary case
        for (int i = 0; i < LANES; i++) begin xs[i] = (i % 3 == 0) ? 1 : 0; ws[i] = (i % 2 == 0) ? 3 : 2; end
        run_job(16, 1, 1, "R5 binary", 0, 0);

        // R2: zero length and precisions clamp to 1
        xs[0] = 255; ws[0] = 255;
        run_job(0, 0, 0, "R2 clamp", 0, 0);

        // R3 and R8: junk valid and start during run
        for (int i = 0; i < LANES; i++) begin xs[i] = 17 * i + 3; ws[i] = 29 * i + 1; end
        run_job(10, 3, 2, "R3 junk valid", 1, 0);
        run_job(10, 3, 2, "R8 start ignored", 0, 1);

        // R4: every precision pair, random data with high garbage bits
        for (int a = 1; a <= XB; a++) begin
            for (int b = 1; b <= WB; b++) begin
                for (int i = 0; i < LANES; i++) begin
                    xs[i] = $urandom_range(0, 255);
                    ws[i] = $urandom_range(0, 255);
                end
                run_job($urandom_range(1, LANES), a, b, "R4 dot product", 0, 0);
            end
        end

        repeat (4) @(negedge clk);
        check(q_res.size() == 0, "R7 missing done", q_res.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule